// File: doc/BRIEF.md
# Multi-mode 16-bit down-counting timer

This block is one timer channel built around a 16-bit down-counter. The counter counts in one of three ways. It can count ticks of an internal clock divider driven by the system clock. It can count rising edges of an external input, which makes it an event counter. It can also count divider ticks only while the external input is high, which measures the width of a pulse. When the counter takes a step from zero, it reloads from a reload register. At the same time it raises a one-cycle request on `irq_o` and toggles `ser_clk_o`, which can serve as the clock for a serial interface.

Software controls the block through a small register port. Writes take effect on the clock edge. Reads are registered, so `rd_data` shows the register chosen by `rd_addr` one edge later. The external input goes through a two-flop synchronizer. A rising edge of the synchronized input counts as a one-cycle event.

Top module: `tmr16_multimode`

## Requirements
- R1: After a synchronous reset, every register reads back as zero: mode 0, divide field 0, run 0, reload 0 and counter 0. `irq_o` and `ser_clk_o` are both 0.
- R2: In mode 0 (internal clock) with the run bit set, the counter drops by one on each divider tick. With the divide field at 0, there is a tick on every clock cycle.
- R3: A divide field k, for k from 0 to 14, gives exactly one tick in every 2^k consecutive clock cycles.
- R4: A count step taken while the counter holds 0 loads the reload value. `irq_o` is high only in the cycle after such a step, so when the reload value is nonzero the request is a single cycle wide.
- R5: `ser_clk_o` changes level once for every underflow and holds its level at all other times.
- R6: In mode 1 (external clock), the counter drops by one for each rising edge of `ext_in`. In this mode the divider ticks have no effect.
- R7: In mode 2 (pulse width), the counter drops by one on each divider tick while the synchronized `ext_in` is high. It does not count while the input is low.
- R8: With the run bit clear, the counter holds its value.
- R9: A write to the control register with the preset bit set copies the reload register into the counter on that edge. If a count step falls on the same edge, the preset wins: there is no decrement and no underflow.
- R10: While the mode is 3 or the divide field is 15, the counter holds its value even with the run bit set. Both values are reserved.
- R11: The register map is as follows.
  - Address 0 is control: bit 0 is run, bit 1 is preset, and bits 3:2 are the mode. The preset bit always reads back as 0.
  - Address 1 holds the divide field in bits 3:0.
  - Address 2 is the reload register.
  - Address 3 is the counter, and it is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Registered read data |
| ext_in | input | 1 | External event or gate input (asynchronous) |
| irq_o | output | 1 | Underflow request pulse |
| ser_clk_o | output | 1 | Serial clock, toggled on each underflow |

## Verification
A preset command and a count step that would underflow can land on the same clock edge. In that case the preset must win, and neither a reload nor a request may follow. The bench sets this up in three steps:
1. It presets the counter to zero.
2. It changes the reload register and starts the counter in internal mode with no division.
3. On the next edge it writes the preset bit, which is the edge where the underflow tick falls.

The bench then checks that the counter holds the new reload value minus one later tick, and that the request count and the serial clock did not change.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [1:0] {
    MODE_INT = 2'd0,
    MODE_EXT = 2'd1,
    MODE_PWM = 2'd2,
    MODE_RSV = 2'd3
  } tmr_mode_e;

  localparam logic [1:0] ADR_CTRL   = 2'd0;
  localparam logic [1:0] ADR_DIV    = 2'd1;
  localparam logic [1:0] ADR_RELOAD = 2'd2;
  localparam logic [1:0] ADR_COUNT  = 2'd3;

  localparam int CTRL_RUN_BIT    = 0;
  localparam int CTRL_PRESET_BIT = 1;
  localparam int CTRL_MODE_LSB   = 2;
endpackage

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
  parameter int DF_W  = 4,
  parameter int PRE_W = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DF_W-1:0] df,
  output logic            tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  // mask holds df low ones; a tick occurs when those prescaler bits are all set
  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      mask[i] = (i < int'(df));
    end
  end

  assign tick = ((pre_q & mask) == mask);
endmodule

// File: rtl/tmr16_edge_sync.sv
module tmr16_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign level = sh_q[STAGES-1];
  assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr16_count_core.sv
module tmr16_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             uf,
  output logic             ser
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      uf  <= 1'b0;
      ser <= 1'b0;
    end else begin
      uf <= 1'b0;
      if (load) begin
        cnt <= reload;
      end else if (step) begin
        if (cnt == '0) begin
          cnt <= reload;
          uf  <= 1'b1;
          ser <= ~ser;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr16_multimode.sv
module tmr16_multimode #(
  parameter int CNT_W       = 16,
  parameter int DF_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             ext_in,
  output logic             irq_o,
  output logic             ser_clk_o
);
  import tmr16_pkg::*;

  localparam logic [DF_W-1:0] DF_RSV = {DF_W{1'b1}};
  localparam int PRE_W = (1 << DF_W) - 2;

  logic             run_q;
  tmr_mode_e        mode_q;
  logic [DF_W-1:0]  df_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] rd_q;
  logic             tick, ext_level, ext_rise;
  logic             preset_cmd, cfg_legal, mode_sel, step_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      mode_q   <= MODE_INT;
      df_q     <= '0;
      reload_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL: begin
          run_q  <= wr_data[CTRL_RUN_BIT];
          mode_q <= tmr_mode_e'(wr_data[CTRL_MODE_LSB +: 2]);
        end
        ADR_DIV:    df_q     <= wr_data[DF_W-1:0];
        ADR_RELOAD: reload_q <= wr_data;
        default: ;
      endcase
    end
  end

  assign preset_cmd = wr_en && (wr_addr == ADR_CTRL) && wr_data[CTRL_PRESET_BIT];

  tmr16_prescale #(.DF_W(DF_W), .PRE_W(PRE_W)) u_pre (
    .clk (clk),
    .rst (rst),
    .df  (df_q),
    .tick(tick)
  );

  tmr16_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (ext_in),
    .level(ext_level),
    .rise (ext_rise)
  );

  always_comb begin
    case (mode_q)
      MODE_INT: mode_sel = tick;
      MODE_EXT: mode_sel = ext_rise;
      MODE_PWM: mode_sel = tick & ext_level;
      default:  mode_sel = 1'b0;
    endcase
  end

  assign cfg_legal = (mode_q != MODE_RSV) && (df_q != DF_RSV);
  assign step_en   = run_q & cfg_legal & mode_sel;

  tmr16_count_core #(.CNT_W(CNT_W)) u_core (
    .clk   (clk),
    .rst   (rst),
    .step  (step_en),
    .load  (preset_cmd),
    .reload(reload_q),
    .cnt   (cnt),
    .uf    (irq_o),
    .ser   (ser_clk_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      case (rd_addr)
        ADR_CTRL:   rd_q <= CNT_W'({mode_q, 1'b0, run_q});
        ADR_DIV:    rd_q <= CNT_W'(df_q);
        ADR_RELOAD: rd_q <= reload_q;
        default:    rd_q <= cnt;
      endcase
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
  parameter int CNT_W = 16,
  parameter int DF_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             preset_cmd,
  input logic             run_q,
  input logic [1:0]       mode_q,
  input logic [DF_W-1:0]  df_q,
  input logic [CNT_W-1:0] reload_q,
  input logic [CNT_W-1:0] cnt,
  input logic             step_en,
  input logic             irq_o,
  input logic             ser_clk_o
);
  p_preset_load_r9: assert property (@(posedge clk) disable iff (rst)
    preset_cmd |=> (cnt == $past(reload_q)));

  p_hold_stopped_r8: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !preset_cmd) |=> $stable(cnt));

  p_hold_reserved_r10: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == 2'd3 || df_q == {DF_W{1'b1}}) && !preset_cmd) |=> $stable(cnt));

  p_step_dec_r2: assert property (@(posedge clk) disable iff (rst)
    (step_en && !preset_cmd && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  p_uf_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (step_en && !preset_cmd && cnt == '0) |=> (irq_o && cnt == $past(reload_q)));

  p_irq_cause_r4: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(step_en && !preset_cmd && cnt == '0));

  p_ser_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (ser_clk_o != $past(ser_clk_o)));

  p_ser_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> $stable(ser_clk_o));
endmodule

bind tmr16_multimode tmr16_chk #(.CNT_W(CNT_W), .DF_W(DF_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .preset_cmd(preset_cmd),
  .run_q     (run_q),
  .mode_q    (mode_q),
  .df_q      (df_q),
  .reload_q  (reload_q),
  .cnt       (cnt),
  .step_en   (step_en),
  .irq_o     (irq_o),
  .ser_clk_o (ser_clk_o)
);

// File: tb/tmr16_multimode_tb_top.sv
`timescale 1ns/1ps
module tmr16_multimode_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        ext_in = 1'b0;
  logic        irq_o, ser_clk_o;

  int total = 0, bad = 0;
  int uf_seen = 0, ser_toggles = 0, irq_run = 0, irq_max = 0;
  logic ser_prev = 1'b0;
  int exp_cnt = 0, exp_reload = 0, exp_uf = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr16_multimode dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_in(ext_in),
    .irq_o(irq_o), .ser_clk_o(ser_clk_o)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (irq_o) begin
        uf_seen++;
        irq_run++;
        if (irq_run > irq_max) irq_max = irq_run;
      end else begin
        irq_run = 0;
      end
      if (ser_clk_o != ser_prev) ser_toggles++;
      ser_prev = ser_clk_o;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    rd_addr = a;
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic model_ticks(int n);
    for (int i = 0; i < n; i++) begin
      if (exp_cnt == 0) begin exp_cnt = exp_reload; exp_uf++; end
      else exp_cnt--;
    end
  endtask

  task automatic set_reload_preset(int r);
    wr(2'd2, 16'(r));
    wr(2'd0, 16'h0002);
    exp_reload = r; exp_cnt = r;
  endtask

  // counting enabled on exactly n edges
  task automatic run_for(int n, int mode);
    wr(2'd0, 16'((mode << 2) | 1));
    repeat (n - 1) @(negedge clk);
    wr(2'd0, 16'(mode << 2));
  endtask

  task automatic check_cnt(string tag);
    int v;
    rd(2'd3, v);
    chk(tag, v, exp_cnt);
  endtask

  task automatic t_reset();
    int v;
    rd(2'd0, v); chk("R1 ctrl reset", v, 0);
    rd(2'd1, v); chk("R1 div reset", v, 0);
    rd(2'd2, v); chk("R1 reload reset", v, 0);
    rd(2'd3, v); chk("R1 count reset", v, 0);
    chk("R1 irq reset", int'(irq_o), 0);
    chk("R1 ser reset", int'(ser_clk_o), 0);
  endtask

  task automatic t_internal();
    int v;
    set_reload_preset(5);
    check_cnt("R9 preset while stopped");
    run_for(3, 0); model_ticks(3);
    check_cnt("R2 decrement div1");
    repeat (10) @(negedge clk);
    check_cnt("R8 hold when stopped");
    run_for(3, 0); model_ticks(3);
    check_cnt("R4 reload after zero");
    run_for(12, 0); model_ticks(12);
    check_cnt("R4 two more wraps");
    chk("R4 underflow count", uf_seen, exp_uf);
    chk("R4 pulse width", irq_max, 1);
    chk("R5 serial toggles", ser_toggles, exp_uf);
    chk("R5 serial level", int'(ser_clk_o), exp_uf % 2);
    rd(2'd0, v); chk("R11 preset reads zero", v, 0);
  endtask

  task automatic t_prescale();
    int v;
    set_reload_preset(1000);
    wr(2'd1, 16'd1); run_for(10, 0); model_ticks(5);
    check_cnt("R3 divide by 2");
    wr(2'd1, 16'd3); run_for(64, 0); model_ticks(8);
    check_cnt("R3 divide by 8");
    rd(2'd1, v); chk("R11 div readback", v, 3);
    wr(2'd1, 16'd14); run_for(32768, 0); model_ticks(2);
    check_cnt("R3 divide by 16384");
  endtask

  task automatic t_reserved();
    int v;
    wr(2'd1, 16'd0);
    set_reload_preset(100);
    run_for(20, 3);
    check_cnt("R10 mode 3 holds");
    wr(2'd0, 16'h000D);
    rd(2'd0, v); chk("R11 ctrl readback mode3 run", v, 13);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'd15);
    run_for(20, 0);
    check_cnt("R10 divide 15 holds");
    wr(2'd1, 16'd0);
  endtask

  task automatic t_external();
    wr(2'd1, 16'd3);
    set_reload_preset(50);
    wr(2'd0, 16'h0005);
    repeat (8) @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      ext_in = 1'b1; repeat (3) @(negedge clk);
      ext_in = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    wr(2'd0, 16'h0004);
    model_ticks(4);
    check_cnt("R6 event count ignores divider");
  endtask

  task automatic t_pulse_width();
    wr(2'd1, 16'd2);
    set_reload_preset(300);
    wr(2'd0, 16'h0009);
    repeat (13) @(negedge clk);
    ext_in = 1'b1; repeat (40) @(negedge clk);
    ext_in = 1'b0; repeat (12) @(negedge clk);
    wr(2'd0, 16'h0008);
    model_ticks(10);
    check_cnt("R7 gated width count");
    wr(2'd1, 16'd0);
  endtask

  task automatic t_collision();
    int uf0, tg0;
    set_reload_preset(0);
    wr(2'd2, 16'd9); exp_reload = 9;
    uf0 = uf_seen; tg0 = ser_toggles;
    wr(2'd0, 16'h0001);
    wr(2'd0, 16'h0003); exp_cnt = 9;
    wr(2'd0, 16'h0000); model_ticks(1);
    check_cnt("R9 preset beats underflow");
    chk("R9 no request on collision", uf_seen, uf0);
    chk("R9 no serial toggle on collision", ser_toggles, tg0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_internal();
    t_prescale();
    t_reserved();
    t_external();
    t_pulse_width();
    t_collision();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule